// File: doc/BRIEF.md
# UART Host Register Front End

This block is the software-facing side of a byte-oriented serial port with a fixed frame of 8 data bits and one stop bit. A 32-bit register bus with four word slots reaches a transmit byte queue, a receive byte queue, an interrupt status latch, an interrupt mask and a control word. Software moves bytes through handshake flags inside the data slot. It queues a byte by writing it with the send flag set. It discards the byte at the head of the receive queue by writing the take flag. No separate queue status register exists.

The serial shifters and the bit-rate generator sit outside the block. The transmit shifter sees the head byte and an availability strobe, and takes a byte with `tx_pop`. The receive shifter delivers bytes with `rx_push`. A three-state machine tracks whether the port is off, running, or running with a line break forced. One host interrupt line summarises the masked causes.

Register slots, selected by `reg_idx`: 0 data, 1 control, 2 interrupt status, 3 interrupt mask. Mode machine states: OFF, RUN, BRK. A control write drives every transition. DISABLE goes from any state to OFF. EN_ON goes from OFF to RUN. EN_BRK goes from OFF to BRK. BRK_SET goes from RUN to BRK. BRK_CLR goes from BRK to RUN.

Top module: `uart_host_regs`

## Requirements
- R1: After reset both queues are empty, the port is OFF, the control word, status and mask read 0, `irq` is 0, and the data slot reads 0x200.
- R2: A data-slot write with bit 9 set appends bits 7:0 to the transmit queue. `tx_byte` shows the oldest byte. `tx_avail` is 1 only when the port is not OFF and the queue holds a byte. Each cycle with `tx_pop` and `tx_avail` both high removes one byte, in write order.
- R3: Bit 9 of a data-slot read is 1 while the transmit queue has room and 0 when it holds DEPTH bytes. A send into a full queue is dropped.
- R4: Bit 8 of a data-slot read is 1 while the receive queue holds a byte, and bits 7:0 then carry the oldest byte (0 when the queue is empty). A data-slot write with bit 8 set removes that byte. A take on an empty queue, or an `rx_push` into a full one, changes nothing.
- R5: While OFF, `rx_push` is dropped and `tx_avail` stays 0. Sends are still queued.
- R6: Status bit 0 is set on every cycle that the receive queue is non-empty, so it returns after a clear while bytes remain. Status bit 1 is set when a pop empties the transmit queue. Writing 1 to a status bit clears it, and a set in the same cycle wins.
- R7: `irq` and control bit 7 equal control bit 4 (host enable) ANDed with the OR of the status bits ANDed with the mask bits (bit 0 receive, bit 1 transmit).
- R8: Control bits 1:0 select parity: 0 none, 1 odd, 2 even. A write of code 3 (an unsupported parity) stores 0. The stored code drives `parity`.
- R9: Control bits 3:2 hold the mode field, and a non-zero value leaves OFF. Control bit 5 requests a line break. `tx_break` and the read-back of bit 5 are 1 only in BRK. A break request written while the mode field is 0 is discarded, and clearing the mode field ends a break.
- R10: Control bit 6 reads the `tx_busy` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | 2 | Register slot select |
| wr_en | input | 1 | Write strobe for the selected slot |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Read data of the selected slot |
| tx_byte | output | 8 | Oldest queued transmit byte |
| tx_avail | output | 1 | A transmit byte is ready for the shifter |
| tx_pop | input | 1 | Shifter takes the transmit byte |
| tx_busy | input | 1 | Transmit shifter busy |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_byte | input | 8 | Received byte |
| irq | output | 1 | Host interrupt |
| uart_en | output | 1 | Port is not OFF |
| tx_break | output | 1 | Force a break on the line |
| parity | output | 2 | Parity code in use |

## Verification
On every cycle, the assertions check that a break is never driven while the port is OFF and that no transmit byte is offered while the port is OFF. They also check that the queue counts never pass DEPTH, that a non-empty receive queue sets the receive status bit on the next cycle, that `irq` stays low without host enable, and that the unsupported parity code is never held. Only the bench scenarios can show byte ordering through both queues, that a send into a full queue or a take from an empty one is dropped, that a cleared status bit returns, and that the mode transitions and the read-back of every field are correct.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;
    localparam int BYTE_W = 8;

    localparam logic [1:0] SLOT_DATA = 2'd0;
    localparam logic [1:0] SLOT_CTRL = 2'd1;
    localparam logic [1:0] SLOT_STAT = 2'd2;
    localparam logic [1:0] SLOT_MASK = 2'd3;

    localparam int DB_RXF = 8;
    localparam int DB_TXF = 9;

    localparam int CB_MODE_LO = 2;
    localparam int CB_HIEN    = 4;
    localparam int CB_BRK     = 5;
    localparam int CB_BUSY    = 6;
    localparam int CB_HINT    = 7;

    localparam logic [1:0] PAR_NONE = 2'd0;
    localparam logic [1:0] PAR_ODD  = 2'd1;
    localparam logic [1:0] PAR_EVEN = 2'd2;
    localparam logic [1:0] PAR_BAD  = 2'd3;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_RUN = 2'd1,
        ST_BRK = 2'd2
    } mode_state_t;
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty,
    output logic             drained,
    output logic [$clog2(DEPTH):0] count
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drained = do_pop && !do_push && (count == (AW+1)'(1));
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/uart_mode_fsm.sv
module uart_mode_fsm
    import uart_host_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic        req_on,
    input  logic        req_brk,
    output mode_state_t state,
    output logic        uart_en,
    output logic        brk_on
);
    mode_state_t nxt;

    always_comb begin
        nxt = state;
        if (ctrl_wr) begin
            unique case (state)
                ST_OFF:  nxt = !req_on ? ST_OFF : (req_brk ? ST_BRK : ST_RUN); // EN_ON / EN_BRK
                ST_RUN:  nxt = !req_on ? ST_OFF : (req_brk ? ST_BRK : ST_RUN); // DISABLE / BRK_SET
                ST_BRK:  nxt = !req_on ? ST_OFF : (req_brk ? ST_BRK : ST_RUN); // DISABLE / BRK_CLR
                default: nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        uart_en = 1'b0;
        brk_on  = 1'b0;
        unique case (state)
            ST_OFF:  begin uart_en = 1'b0; brk_on = 1'b0; end
            ST_RUN:  begin uart_en = 1'b1; brk_on = 1'b0; end
            ST_BRK:  begin uart_en = 1'b1; brk_on = 1'b1; end
            default: begin uart_en = 1'b0; brk_on = 1'b0; end
        endcase
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stat_wr,
    input  logic       mask_wr,
    input  logic [1:0] wbits,
    input  logic       rx_nonempty,
    input  logic       tx_drained,
    input  logic       host_en,
    output logic [1:0] stat_q,
    output logic [1:0] mask_q,
    output logic       host_int
);
    logic [1:0] set_v, clr_v;

    assign set_v    = {tx_drained, rx_nonempty};
    assign clr_v    = stat_wr ? wbits : 2'b00;
    assign host_int = host_en && (|(stat_q & mask_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 2'b00;
            mask_q <= 2'b00;
        end else begin
            stat_q <= (stat_q & ~clr_v) | set_v;
            if (mask_wr) mask_q <= wbits;
        end
    end
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
    import uart_host_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_idx,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic [7:0]       tx_byte,
    output logic             tx_avail,
    input  logic             tx_pop,
    input  logic             tx_busy,
    input  logic             rx_push,
    input  logic [7:0]       rx_byte,
    output logic             irq,
    output logic             uart_en,
    output logic             tx_break,
    output logic [1:0]       parity
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic              wr_data, wr_ctrl, wr_stat, wr_mask;
    logic              tx_full, tx_empty, tx_drained;
    logic              rx_full, rx_empty, rx_drained;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic [BYTE_W-1:0] rx_head;
    logic [1:0]        parity_q, mode_q;
    logic              hien_q;
    logic [1:0]        stat_q, mask_q;
    logic              host_int;
    mode_state_t       mstate;

    assign wr_data = wr_en && (reg_idx == SLOT_DATA);
    assign wr_ctrl = wr_en && (reg_idx == SLOT_CTRL);
    assign wr_stat = wr_en && (reg_idx == SLOT_STAT);
    assign wr_mask = wr_en && (reg_idx == SLOT_MASK);

    assign tx_avail = uart_en && !tx_empty;

    uart_byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_txq (
        .clk, .rst_n,
        .push    (wr_data && wdata[DB_TXF]),
        .din     (wdata[BYTE_W-1:0]),
        .pop     (tx_pop && tx_avail),
        .dout    (tx_byte),
        .full    (tx_full),
        .empty   (tx_empty),
        .drained (tx_drained),
        .count   (tx_cnt)
    );

    uart_byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_rxq (
        .clk, .rst_n,
        .push    (rx_push && uart_en),
        .din     (rx_byte),
        .pop     (wr_data && wdata[DB_RXF]),
        .dout    (rx_head),
        .full    (rx_full),
        .empty   (rx_empty),
        .drained (rx_drained),
        .count   (rx_cnt)
    );

    uart_mode_fsm u_mode (
        .clk, .rst_n,
        .ctrl_wr (wr_ctrl),
        .req_on  (|wdata[CB_MODE_LO+1:CB_MODE_LO]),
        .req_brk (wdata[CB_BRK]),
        .state   (mstate),
        .uart_en (uart_en),
        .brk_on  (tx_break)
    );

    uart_irq_ctrl u_irq (
        .clk, .rst_n,
        .stat_wr     (wr_stat),
        .mask_wr     (wr_mask),
        .wbits       (wdata[1:0]),
        .rx_nonempty (!rx_empty),
        .tx_drained  (tx_drained),
        .host_en     (hien_q),
        .stat_q      (stat_q),
        .mask_q      (mask_q),
        .host_int    (host_int)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            parity_q <= PAR_NONE;
            mode_q   <= 2'b00;
            hien_q   <= 1'b0;
        end else if (wr_ctrl) begin
            parity_q <= (wdata[1:0] == PAR_BAD) ? PAR_NONE : wdata[1:0];
            mode_q   <= wdata[CB_MODE_LO+1:CB_MODE_LO];
            hien_q   <= wdata[CB_HIEN];
        end
    end

    assign irq    = host_int;
    assign parity = parity_q;

    always_comb begin
        rdata = '0;
        unique case (reg_idx)
            SLOT_DATA: begin
                rdata[DB_TXF]       = !tx_full;
                rdata[DB_RXF]       = !rx_empty;
                rdata[BYTE_W-1:0]   = rx_empty ? '0 : rx_head;
            end
            SLOT_CTRL: begin
                rdata[1:0]                      = parity_q;
                rdata[CB_MODE_LO+1:CB_MODE_LO]  = mode_q;
                rdata[CB_HIEN]                  = hien_q;
                rdata[CB_BRK]                   = (mstate == ST_BRK);
                rdata[CB_BUSY]                  = tx_busy;
                rdata[CB_HINT]                  = host_int;
            end
            SLOT_STAT: rdata[1:0] = stat_q;
            SLOT_MASK: rdata[1:0] = mask_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_host_regs_chk.sv
module uart_host_regs_chk #(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic          hien_q,
    input logic          uart_en,
    input logic          tx_avail,
    input logic          tx_break,
    input logic [1:0]    parity,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic [1:0]    stat_q
);
    a_r9_break_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        tx_break |-> uart_en);
    a_r5_no_tx_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !uart_en |-> !tx_avail);
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CW'(DEPTH));
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(DEPTH));
    a_r6_rx_sets_stat: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt != '0) |=> stat_q[0]);
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !hien_q |-> !irq);
    a_r8_no_bad_parity: assert property (@(posedge clk) disable iff (!rst_n)
        parity != 2'd3);
endmodule

bind uart_host_regs uart_host_regs_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .hien_q   (hien_q),
    .uart_en  (uart_en),
    .tx_avail (tx_avail),
    .tx_break (tx_break),
    .parity   (parity),
    .tx_cnt   (tx_cnt),
    .rx_cnt   (rx_cnt),
    .stat_q   (stat_q)
);

// File: tb/uart_host_regs_bench.sv
`timescale 1ns/100ps
module uart_host_regs_bench;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_idx = 2'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  tx_byte;
    logic        tx_avail;
    logic        tx_pop = 1'b0;
    logic        tx_busy = 1'b0;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        irq, uart_en, tx_break;
    logic [1:0]  parity;

    int checks = 0;
    int errors = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    bit model_en = 1'b0;

    always #2 clk = ~clk;

    uart_host_regs #(.DEPTH(DEPTH)) u_uart_host_regs (
        .clk, .rst_n, .reg_idx, .wr_en, .wdata, .rdata,
        .tx_byte, .tx_avail, .tx_pop, .tx_busy,
        .rx_push, .rx_byte, .irq, .uart_en, .tx_break, .parity
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every byte the shifter takes must match the driver's queue (R2)
    always @(negedge clk) begin
        if (rst_n && tx_pop && tx_avail) begin
            if (txq.size() == 0) check("R2 unexpected tx byte", {24'h0, tx_byte}, 32'hFFFF);
            else                 check("R2 tx order", {24'h0, tx_byte}, {24'h0, txq.pop_front()});
        end
    end

    task automatic wr(input logic [1:0] idx, input logic [31:0] d);
        reg_idx = idx; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [31:0] d);
        reg_idx = idx;
        @(negedge clk); d = rdata;
        @(posedge clk); #1;
    endtask

    task automatic send(input logic [7:0] b);
        if (txq.size() < DEPTH) txq.push_back(b);
        wr(2'd0, 32'h200 | b);
    endtask

    task automatic feed(input logic [7:0] b);
        if (model_en && rxq.size() < DEPTH) rxq.push_back(b);
        rx_byte = b; rx_push = 1'b1;
        @(posedge clk); #1;
        rx_push = 1'b0;
    endtask

    task automatic take(input string tag);
        logic [31:0] d;
        logic [7:0]  e;
        rd(2'd0, d);
        e = (rxq.size() != 0) ? rxq.pop_front() : 8'h00;
        check(tag, d[8:0], {(e != 8'h00) || d[8] ? 1'b1 : 1'b0, e});
        wr(2'd0, 32'h100);
    endtask

    task automatic drain(input int n);
        tx_pop = 1'b1;
        repeat (n) begin @(posedge clk); #1; end
        tx_pop = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, d); check("R1 data", d, 32'h200);
        rd(2'd1, d); check("R1 ctrl", d, 32'h0);
        rd(2'd2, d); check("R1 stat", d, 32'h0);
        rd(2'd3, d); check("R1 mask", d, 32'h0);
        check("R1 irq/en/avail", {irq, uart_en, tx_avail}, 3'b000);

        // R9/R8 enable, odd parity
        wr(2'd1, 32'h05); model_en = 1'b1;
        rd(2'd1, d); check("R9 ctrl readback", d, 32'h05);
        check("R9 uart_en", uart_en, 1'b1);
        check("R8 parity odd", parity, 2'd1);

        // R2 send three, drain, R6 tx-empty status
        send(8'hA1); send(8'hB2); send(8'hC3);
        check("R2 tx_avail", tx_avail, 1'b1);
        drain(3);
        check("R2 queue consumed", txq.size(), 0);
        rd(2'd2, d); check("R6 tx drained sets bit1", d, 32'h2);
        wr(2'd2, 32'h2);
        rd(2'd2, d); check("R6 w1c clears", d, 32'h0);

        // R3 full queue and dropped send
        send(8'h10); send(8'h20); send(8'h30); send(8'h40);
        rd(2'd0, d); check("R3 tx flag full", d[9], 1'b0);
        send(8'hEE);
        drain(DEPTH);
        check("R3 drop kept order", txq.size(), 0);
        check("R3 tx_avail after drain", tx_avail, 1'b0);
        rd(2'd0, d); check("R3 tx flag room", d[9], 1'b1);

        // R4 receive path
        feed(8'h11); feed(8'h22);
        take("R4 rx head 1"); take("R4 rx head 2");
        wr(2'd0, 32'h100);
        rd(2'd0, d); check("R4 empty take no effect", d, 32'h200);
        for (int i = 0; i < DEPTH + 1; i++) feed(8'h60 + 8'(i));
        for (int i = 0; i < DEPTH; i++) take("R4 rx overflow order");
        rd(2'd0, d); check("R4 overflow byte dropped", d, 32'h200);
        wr(2'd2, 32'h3);

        // R7 interrupt gating, R6 re-set
        wr(2'd3, 32'h1);
        feed(8'h77);
        check("R7 irq without host en", irq, 1'b0);
        rd(2'd1, d); check("R7 ctrl bit7 gated", d[7], 1'b0);
        wr(2'd1, 32'h15);
        check("R7 irq", irq, 1'b1);
        rd(2'd1, d); check("R7 ctrl readback", d, 32'h95);
        wr(2'd2, 32'h1);
        rd(2'd2, d); check("R6 rx bit returns", d, 32'h1);
        take("R4 rx 77");
        wr(2'd2, 32'h1);
        rd(2'd2, d); check("R6 rx bit cleared", d, 32'h0);
        check("R7 irq cleared", irq, 1'b0);

        // R8 parity codes
        wr(2'd1, 32'h07); check("R8 code3 stored none", parity, 2'd0);
        rd(2'd1, d); check("R8 ctrl readback", d[1:0], 2'd0);
        wr(2'd1, 32'h06); check("R8 even", parity, 2'd2);

        // R9 break
        wr(2'd1, 32'h24); check("R9 break on", tx_break, 1'b1);
        rd(2'd1, d); check("R9 break readback", d[5], 1'b1);
        wr(2'd1, 32'h20); model_en = 1'b0;
        check("R9 off ends break", {uart_en, tx_break}, 2'b00);
        rd(2'd1, d); check("R9 break discarded", d[5], 1'b0);

        // R5 disabled behaviour
        feed(8'h55);
        rd(2'd0, d); check("R5 rx ignored when off", d[8], 1'b0);
        send(8'h5A);
        check("R5 no tx_avail when off", tx_avail, 1'b0);
        wr(2'd1, 32'h04); model_en = 1'b1;
        check("R5 tx_avail after enable", tx_avail, 1'b1);
        drain(1);
        check("R5 queued byte sent", txq.size(), 0);

        // R10 busy mirror
        tx_busy = 1'b1; rd(2'd1, d); check("R10 busy 1", d[6], 1'b1);
        tx_busy = 1'b0; rd(2'd1, d); check("R10 busy 0", d[6], 1'b0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule